// File: doc/BRIEF.md
# Read Response Segmenter and Reassembly Tracker

This block serves remote memory READ operations on both sides of a reliable connection. On the responder side it takes one accepted read request, made of a start address, a byte length and a starting sequence number. It turns that request into a run of response packet descriptors, one per clock cycle. Each descriptor acts as a memory-read command for one packet's payload. It carries the packet's address, payload length, sequence number and a position opcode. The request packet itself carries no payload, and every byte of data travels in the responses. A read longer than the negotiated MTU is split across several responses.

On the requester side, a tracker is armed with the same request information. It follows the responses that come back and checks that each one holds the next expected sequence number. It raises a done pulse only once the whole message has arrived in order. A sequence gap stops the tracker and raises an error flag, and no completion is given for that message.

Top module: `rdseg_read_responder`

## Requirements
- R1: `mtu_sel` values 0, 1, 2, 3 and 4 select an MTU of 256, 512, 1024, 2048 and 4096 bytes. Any larger code selects 4096. The value is captured when a request is accepted or the tracker is armed.
- R2: A request of L bytes with an MTU of M yields max(1, ceil(L/M)) descriptors. Every descriptor except the final one has `desc_len` equal to M. The final one carries the remainder.
- R3: The opcode encoding is FIRST=0, MIDDLE=1, LAST=2, ONLY=3. A single-packet read emits ONLY. A longer read emits FIRST, then zero or more MIDDLE, then LAST.
- R4: A zero-length read emits exactly one ONLY descriptor with `desc_len` 0.
- R5: Descriptor sequence numbers start at the request's number and increase by one per packet, modulo 2^PSN_W.
- R6: Each descriptor's address equals the previous descriptor's address plus the previous payload length.
- R7: Descriptors appear one per cycle, starting in the cycle after acceptance. `req_ready` stays low from acceptance through the final descriptor's cycle and is high in the cycle after it.
- R8: The tracker raises `rd_done` for exactly one cycle, in the cycle after the final expected response is taken. This happens only when every response arrived with the expected sequence number.
- R9: A response whose sequence number is not the expected one sets `rd_err`, clears `rd_busy` and suppresses `rd_done` for that message. `rd_err` stays set until the next arm.
- R10: After reset, `req_ready`=1, `desc_valid`=0, `rd_busy`=0, `rd_done`=0 and `rd_err`=0.
- R11: A response presented while the tracker is not armed is ignored: it raises neither `rd_done` nor `rd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mtu_sel | input | 3 | MTU code, captured on accept or arm |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Segmenter idle, request can be taken |
| req_addr | input | ADDR_W | Start address of the read |
| req_len | input | LEN_W | Read length in bytes |
| req_psn | input | PSN_W | Sequence number of the first response |
| desc_valid | output | 1 | Descriptor present this cycle |
| desc_op | output | 2 | Position opcode of the packet |
| desc_addr | output | ADDR_W | Memory address of the packet payload |
| desc_len | output | PLEN_W | Payload bytes of the packet |
| desc_psn | output | PSN_W | Sequence number of the packet |
| trk_arm | input | 1 | Start tracking a new message |
| trk_psn | input | PSN_W | First expected response number |
| trk_len | input | LEN_W | Length of the tracked read |
| rsp_valid | input | 1 | A response packet arrived |
| rsp_psn | input | PSN_W | Its sequence number |
| rd_busy | output | 1 | Tracker waiting for responses |
| rd_done | output | 1 | One-cycle message-complete pulse |
| rd_err | output | 1 | Sequence error seen, held until next arm |

## Verification
The bench builds the block with its defaults: a 48-bit address, a 32-bit length, a 24-bit sequence number and five MTU steps starting at 256 bytes. The 24-bit sequence width lets a directed case start at the top code and cross the wrap to zero in the middle of a message. The five MTU steps, together with select codes 5 to 7, let random requests of up to 9000 bytes cover every MTU value as well as the clamp. Those lengths also reach single-packet reads, exact multiples of the MTU and messages of up to about 36 packets. The responses are fed back from the descriptors with a sequence number that is sometimes corrupted. This exercises error detection with a mismatch at the first, middle or last packet.

// File: rtl/rdseg_pkg.sv
package rdseg_pkg;
   typedef enum logic [1:0] {
      OP_FIRST  = 2'd0,
      OP_MIDDLE = 2'd1,
      OP_LAST   = 2'd2,
      OP_ONLY   = 2'd3
   } seg_op_e;
endpackage

// File: rtl/rdseg_mtu_decode.sv
module rdseg_mtu_decode #(
   parameter int MIN_LOG2 = 8,
   parameter int STEPS    = 5,
   parameter int SEL_W    = 3,
   parameter int SH_W     = 4
) (
   input  logic [SEL_W-1:0] sel,
   output logic [SH_W-1:0]  shift
);
   localparam int MAX_LOG2 = MIN_LOG2 + STEPS - 1;

   generate
      if (STEPS < 1 || MAX_LOG2 >= (1 << SH_W)) begin : g_bad
         $error("rdseg_mtu_decode: MTU range does not fit shift width");
      end
      if (STEPS == 1) begin : g_fixed
         assign shift = SH_W'(MIN_LOG2);
      end else begin : g_sel
         always_comb begin
            if (32'(sel) >= STEPS) shift = SH_W'(MAX_LOG2);
            else                   shift = SH_W'(MIN_LOG2) + SH_W'(sel);
         end
      end
   endgenerate
endmodule

// File: rtl/rdseg_segmenter.sv
module rdseg_segmenter
   import rdseg_pkg::*;
#(
   parameter int ADDR_W = 48,
   parameter int LEN_W  = 32,
   parameter int PSN_W  = 24,
   parameter int SH_W   = 4,
   parameter int PLEN_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SH_W-1:0]   shift_in,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [PSN_W-1:0]  req_psn,
   output logic              desc_valid,
   output logic [1:0]        desc_op,
   output logic [ADDR_W-1:0] desc_addr,
   output logic [PLEN_W-1:0] desc_len,
   output logic [PSN_W-1:0]  desc_psn
);
   logic              busy_q, first_q;
   logic [LEN_W-1:0]  rem_q;
   logic [ADDR_W-1:0] addr_q;
   logic [PSN_W-1:0]  psn_q;
   logic [SH_W-1:0]   sh_q;
   logic [LEN_W-1:0]  mtu_w, take;
   logic              fits, accept;
   seg_op_e           op;

   assign mtu_w  = LEN_W'(1) << sh_q;
   assign fits   = (rem_q <= mtu_w);
   assign take   = fits ? rem_q : mtu_w;
   assign accept = req_valid && !busy_q;

   always_comb begin
      case ({first_q, fits})
         2'b11:   op = OP_ONLY;
         2'b10:   op = OP_FIRST;
         2'b01:   op = OP_LAST;
         default: op = OP_MIDDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         first_q <= 1'b0;
         rem_q   <= '0;
         addr_q  <= '0;
         psn_q   <= '0;
         sh_q    <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         first_q <= 1'b1;
         rem_q   <= req_len;
         addr_q  <= req_addr;
         psn_q   <= req_psn;
         sh_q    <= shift_in;
      end else if (busy_q) begin
         rem_q   <= rem_q - take;
         addr_q  <= addr_q + ADDR_W'(take);
         psn_q   <= psn_q + 1'b1;
         first_q <= 1'b0;
         if (fits) busy_q <= 1'b0;
      end
   end

   assign req_ready  = !busy_q;
   assign desc_valid = busy_q;
   assign desc_op    = op;
   assign desc_addr  = addr_q;
   assign desc_len   = PLEN_W'(take);
   assign desc_psn   = psn_q;

   p_psn_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && !fits |=> desc_valid && desc_psn == $past(desc_psn) + 1'b1);
   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && !fits |=> desc_addr == $past(desc_addr) + ADDR_W'($past(desc_len)));
   p_open_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(desc_valid) |-> (desc_op == OP_FIRST || desc_op == OP_ONLY));
   p_mid_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && (desc_op == OP_FIRST || desc_op == OP_MIDDLE)
      |=> desc_valid && (desc_op == OP_MIDDLE || desc_op == OP_LAST));
   p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && !fits |=> !req_ready);
endmodule

// File: rtl/rdseg_tracker.sv
module rdseg_tracker #(
   parameter int LEN_W = 32,
   parameter int PSN_W = 24,
   parameter int SH_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SH_W-1:0]  shift_in,
   input  logic             arm,
   input  logic [PSN_W-1:0] arm_psn,
   input  logic [LEN_W-1:0] arm_len,
   input  logic             rsp_valid,
   input  logic [PSN_W-1:0] rsp_psn,
   output logic             busy,
   output logic             done,
   output logic             err
);
   localparam int CNT_W = LEN_W + 1;

   logic             busy_q, done_q, err_q;
   logic [PSN_W-1:0] exp_q;
   logic [CNT_W-1:0] left_q, mtu_w, cnt_raw, cnt;

   assign mtu_w   = CNT_W'(1) << shift_in;
   assign cnt_raw = ({1'b0, arm_len} + (mtu_w - 1'b1)) >> shift_in;
   assign cnt     = (cnt_raw == '0) ? CNT_W'(1) : cnt_raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         exp_q  <= '0;
         left_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (arm) begin
            busy_q <= 1'b1;
            err_q  <= 1'b0;
            exp_q  <= arm_psn;
            left_q <= cnt;
         end else if (busy_q && rsp_valid) begin
            if (rsp_psn == exp_q) begin
               exp_q  <= exp_q + 1'b1;
               left_q <= left_q - 1'b1;
               if (left_q == CNT_W'(1)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end else begin
               err_q  <= 1'b1;
               busy_q <= 1'b0;
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign err  = err_q;

   p_done_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !err);
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_idle_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !arm |=> !done && $stable(err));
endmodule

// File: rtl/rdseg_read_responder.sv
module rdseg_read_responder #(
   parameter int ADDR_W   = 48,
   parameter int LEN_W    = 32,
   parameter int PSN_W    = 24,
   parameter int MIN_LOG2 = 8,
   parameter int STEPS    = 5,
   parameter int SEL_W    = 3,
   localparam int MAX_LOG2 = MIN_LOG2 + STEPS - 1,
   localparam int SH_W     = $clog2(MAX_LOG2 + 1),
   localparam int PLEN_W   = MAX_LOG2 + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  mtu_sel,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [PSN_W-1:0]  req_psn,
   output logic              desc_valid,
   output logic [1:0]        desc_op,
   output logic [ADDR_W-1:0] desc_addr,
   output logic [PLEN_W-1:0] desc_len,
   output logic [PSN_W-1:0]  desc_psn,
   input  logic              trk_arm,
   input  logic [PSN_W-1:0]  trk_psn,
   input  logic [LEN_W-1:0]  trk_len,
   input  logic              rsp_valid,
   input  logic [PSN_W-1:0]  rsp_psn,
   output logic              rd_busy,
   output logic              rd_done,
   output logic              rd_err
);
   generate
      if (LEN_W <= MAX_LOG2) begin : g_len_chk
         $error("rdseg_read_responder: LEN_W must exceed largest MTU exponent");
      end
      if (PSN_W < 2 || ADDR_W < PLEN_W) begin : g_w_chk
         $error("rdseg_read_responder: PSN_W or ADDR_W too small");
      end
   endgenerate

   logic [SH_W-1:0] shift;

   rdseg_mtu_decode #(
      .MIN_LOG2(MIN_LOG2), .STEPS(STEPS), .SEL_W(SEL_W), .SH_W(SH_W)
   ) u_mtu (
      .sel(mtu_sel), .shift(shift)
   );

   rdseg_segmenter #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PSN_W(PSN_W), .SH_W(SH_W), .PLEN_W(PLEN_W)
   ) u_seg (
      .clk(clk), .rst_n(rst_n), .shift_in(shift),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_psn(req_psn),
      .desc_valid(desc_valid), .desc_op(desc_op), .desc_addr(desc_addr),
      .desc_len(desc_len), .desc_psn(desc_psn)
   );

   rdseg_tracker #(
      .LEN_W(LEN_W), .PSN_W(PSN_W), .SH_W(SH_W)
   ) u_trk (
      .clk(clk), .rst_n(rst_n), .shift_in(shift),
      .arm(trk_arm), .arm_psn(trk_psn), .arm_len(trk_len),
      .rsp_valid(rsp_valid), .rsp_psn(rsp_psn),
      .busy(rd_busy), .done(rd_done), .err(rd_err)
   );
endmodule

// File: tb/tb_rdseg_read_responder.sv
module tb_rdseg_read_responder;
   localparam int ADDR_W = 48;
   localparam int LEN_W  = 32;
   localparam int PSN_W  = 24;
   localparam int PLEN_W = 13;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [2:0]        mtu_sel;
   logic              req_valid;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr;
   logic [LEN_W-1:0]  req_len;
   logic [PSN_W-1:0]  req_psn;
   logic              desc_valid;
   logic [1:0]        desc_op;
   logic [ADDR_W-1:0] desc_addr;
   logic [PLEN_W-1:0] desc_len;
   logic [PSN_W-1:0]  desc_psn;
   logic              trk_arm;
   logic [PSN_W-1:0]  trk_psn;
   logic [LEN_W-1:0]  trk_len;
   logic              rsp_valid;
   logic [PSN_W-1:0]  rsp_psn;
   logic              rd_busy, rd_done, rd_err;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   rdseg_read_responder dut (
      .clk(clk), .rst_n(rst_n), .mtu_sel(mtu_sel),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_psn(req_psn),
      .desc_valid(desc_valid), .desc_op(desc_op), .desc_addr(desc_addr),
      .desc_len(desc_len), .desc_psn(desc_psn),
      .trk_arm(trk_arm), .trk_psn(trk_psn), .trk_len(trk_len),
      .rsp_valid(rsp_valid), .rsp_psn(rsp_psn),
      .rd_busy(rd_busy), .rd_done(rd_done), .rd_err(rd_err)
   );

   function automatic int mtu_of(input int sel);
      return (sel >= 5) ? 4096 : (256 << sel);
   endfunction

   function automatic int pkts_of(input int len, input int sel);
      int m = mtu_of(sel);
      int n = (len + m - 1) / m;
      return (n == 0) ? 1 : n;
   endfunction

   function automatic int op_of(input int i, input int n);
      if (n == 1)     return 3;
      if (i == 0)     return 0;
      if (i == n - 1) return 2;
      return 1;
   endfunction

   task automatic check(input bit ok, input string req, input string msg,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
      end
   endtask

   // one request through segmenter and tracker; corrupt < 0 means clean run
   task automatic run_req(input logic [ADDR_W-1:0] addr, input int len,
                          input logic [PSN_W-1:0] psn, input int sel, input int corrupt);
      int n = pkts_of(len, sel);
      int m = mtu_of(sel);
      @(negedge clk);
      mtu_sel = 3'(sel); req_valid = 1'b1; req_addr = addr;
      req_len = LEN_W'(len); req_psn = psn;
      trk_arm = 1'b1; trk_psn = psn; trk_len = LEN_W'(len);
      @(negedge clk);
      req_valid = 1'b0; trk_arm = 1'b0;
      check(rd_err == 1'b0, "R9", "error cleared by arm", rd_err, 0);
      for (int i = 0; i < n; i++) begin
         logic [ADDR_W-1:0] ea = addr + ADDR_W'(i * m);
         logic [PSN_W-1:0]  ep = psn + PSN_W'(i);
         int el = (i < n - 1) ? m : len - (n - 1) * m;
         check(desc_valid == 1'b1, "R7", "descriptor present", desc_valid, 1);
         check(int'(desc_op) == op_of(i, n), "R3", "position opcode", desc_op, op_of(i, n));
         check(int'(desc_len) == el, (len == 0) ? "R4" : "R2", "payload length", desc_len, el);
         check(desc_psn == ep, "R5", "sequence number", desc_psn, ep);
         check(desc_addr == ea, "R6", "payload address", desc_addr, ea);
         check(req_ready == 1'b0, "R7", "ready low while segmenting", req_ready, 0);
         if (corrupt >= 0)
            check(rd_done == 1'b0, "R9", "no done on bad message", rd_done, 0);
         rsp_valid = 1'b1;
         rsp_psn = (i == corrupt) ? desc_psn + PSN_W'(7) : desc_psn;
         @(negedge clk);
      end
      rsp_valid = 1'b0;
      check(desc_valid == 1'b0, "R2", "no extra descriptor", desc_valid, 0);
      check(req_ready == 1'b1, "R7", "ready after final descriptor", req_ready, 1);
      if (corrupt < 0) begin
         check(rd_done == 1'b1, "R8", "done pulse", rd_done, 1);
         check(rd_err == 1'b0, "R8", "no error", rd_err, 0);
         @(negedge clk);
         check(rd_done == 1'b0, "R8", "done lasts one cycle", rd_done, 0);
      end else begin
         check(rd_done == 1'b0, "R9", "done suppressed", rd_done, 0);
         check(rd_err == 1'b1 && rd_busy == 1'b0, "R9", "error raised, tracker stopped",
               {rd_err, rd_busy}, 2'b10);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; mtu_sel = '0; req_valid = 1'b0; req_addr = '0; req_len = '0;
      req_psn = '0; trk_arm = 1'b0; trk_psn = '0; trk_len = '0;
      rsp_valid = 1'b0; rsp_psn = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !desc_valid && !rd_busy && !rd_done && !rd_err, "R10",
            "reset state", {req_ready, desc_valid, rd_busy, rd_done, rd_err}, 5'b10000);

      // R11: response while tracker idle
      rsp_valid = 1'b1; rsp_psn = 24'h000010;
      @(negedge clk);
      rsp_valid = 1'b0;
      check(!rd_done && !rd_err && !rd_busy, "R11", "idle response ignored",
            {rd_done, rd_err, rd_busy}, 0);

      // directed corners
      run_req(48'h0000_1000_0000, 0, 24'h000100, 0, -1);     // R4 zero length
      run_req(48'h0000_2000_0000, 256, 24'h000200, 0, -1);   // R2 exact one MTU
      run_req(48'h0000_3000_0000, 1024, 24'h000300, 0, -1);  // R2 exact multiple
      run_req(48'h0000_4000_0000, 1000, 24'hFFFFFF, 0, -1);  // R5 wrap
      run_req(48'h0000_5000_0000, 4097, 24'h000500, 4, -1);  // R1 largest MTU
      run_req(48'h0000_6000_0000, 5000, 24'h000600, 7, -1);  // R1 clamp code
      run_req(48'h0000_7000_0000, 3000, 24'h000700, 1, 2);   // R9 middle mismatch
      run_req(48'h0000_8000_0000, 600, 24'h000800, 0, 0);    // R9 first mismatch
      run_req(48'h0000_9000_0000, 700, 24'h000900, 1, -1);   // R9 cleared by arm

      for (int k = 0; k < 40; k++) begin
         int sel = int'($urandom % 8);
         int len = (k % 9 == 0) ? 0 : int'($urandom % 9000);
         int n = pkts_of(len, sel);
         int bad = (k % 7 == 3) ? int'($urandom % n) : -1;
         logic [ADDR_W-1:0] a = {$urandom, $urandom} & {ADDR_W{1'b1}};
         run_req(a, len, PSN_W'($urandom), sel, bad);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule